// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

A synchronous controller that runs single-beat reads and writes on a byte-wide asynchronous memory with SRAM-style strobes. It has 524,288 words of 8 bits behind a 19-bit address. A host hands in one request at a time over a valid/ready handshake, with a write flag, an address and write data. A read returns its byte with a one-cycle valid pulse. A write completes silently. A write that arrives while the power-fail inhibit input is high is refused with a one-cycle error pulse.

On the memory side the controller drives active-low chip enable, write enable and output enable, plus the address. It also drives a data bus through a separate output value, a drive enable and an input value. Every memory timing figure is a parameter in picoseconds. Each one is turned into whole clock cycles by rounding up, with a floor of one cycle. A parameter selects one of two write styles. In the first, chip enable is held low and write enable pulses. In the second, write enable is held low and chip enable pulses.

All strobes leave registers, so they change only on clock edges and never glitch. Minimum spacing between chip-enable falling edges is enforced by a counter. Minimum write-enable high time is enforced by a second counter. Both counters hold off the ready signal.

Top module: `sram_bus_ctrl`

## Requirements
- R1: A read drives chip enable and output enable low in the same cycle as the new address. It keeps them low for ACC_N cycles, with ACC_N = ceil(T_ACC_PS/CLK_PS). It then captures the data bus and pulses rd_valid_o high for exactly one cycle, with rd_data_o holding the captured byte.
- R2: With WE_CTRL=1, a write holds chip enable low one cycle before write enable falls. Write enable then stays low for WP_N = ceil(T_WP_PS/CLK_PS) cycles, and both strobes rise on the same edge.
- R3: With WE_CTRL=0, a write holds write enable low one cycle before chip enable falls. Chip enable then stays low for WP_N cycles, and both strobes rise on the same edge.
- R4: Output enable is high in every cycle in which the data driver is enabled. The driver is on from the write setup cycle through DH_N = ceil(T_DH_PS/CLK_PS) cycles after the strobes rise, so the written byte is driven during the whole strobe overlap.
- R5: Two falling edges of chip enable are never closer than CYC_N = ceil(T_CYC_PS/CLK_PS) cycles.
- R6: After write enable rises, it stays high for at least REC_N = ceil(T_WEH_PS/CLK_PS) cycles before it falls again.
- R7: A write request accepted while wr_inhibit_i is high completes in its accept cycle. wr_err_o pulses in the next cycle. No strobe moves, ready stays high, and the addressed byte keeps its old value.
- R8: req_ready_o is low from the cycle after an accepted memory request until the cycle finishes and both spacing counters expire. With the default timing it is high in the cycle that carries rd_valid_o.
- R9: The memory address does not change while chip enable stays low.
- R10: Out of reset, all three strobes are high, the data driver is off, ready is high and both response pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller can take a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 19 | Word address |
| req_wdata_i | input | 8 | Write byte |
| wr_inhibit_i | input | 1 | Power-fail write block |
| rd_valid_o | output | 1 | One-cycle read data strobe |
| rd_data_o | output | 8 | Read byte |
| wr_err_o | output | 1 | One-cycle refused-write strobe |
| mem_ce_no | output | 1 | Memory chip enable, active low |
| mem_we_no | output | 1 | Memory write enable, active low |
| mem_oe_no | output | 1 | Memory output enable, active low |
| mem_addr_o | output | 19 | Memory address |
| mem_dq_o | output | 8 | Data bus drive value |
| mem_dq_oe_o | output | 1 | Data bus drive enable |
| mem_dq_i | input | 8 | Data bus sampled value |

## Verification
The end of a read and the acceptance of the next request can fall in the same cycle. rd_valid_o is high while ready has just returned. The bench calls each new request straight from the cycle in which it sees rd_valid_o, so the next request is taken on the edge that closes that read, and random mixes of back-to-back reads and writes repeat the overlap. This is judged by the returned byte, by ready being high in the valid cycle, and by a monitor that measures chip-enable fall spacing and write-enable high time on the pins of a memory model. That model only returns data after the access count and only stores a byte after a full-width strobe overlap.

// File: rtl/sram_bus_pkg.sv
package sram_bus_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD,
    S_WSU,
    S_WP,
    S_WH
  } sbc_state_e;

  // round a picosecond figure up to whole clocks, at least one
  function automatic int to_cycles(int ps, int clk_ps);
    int n;
    n = (ps + clk_ps - 1) / clk_ps;
    return (n < 1) ? 1 : n;
  endfunction

endpackage

// File: rtl/sbc_down_cnt.sv
module sbc_down_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sbc_wr_strobe.sv
module sbc_wr_strobe #(
  parameter bit WE_CTRL = 1'b1
) (
  input  logic setup_i,
  input  logic pulse_i,
  output logic ce_n_o,
  output logic we_n_o
);

  generate
    if (WE_CTRL) begin : g_we_ctrl
      // chip enable frames the cycle, write enable times the write
      assign ce_n_o = !(setup_i || pulse_i);
      assign we_n_o = !pulse_i;
    end else begin : g_ce_ctrl
      // write enable frames the cycle, chip enable times the write
      assign ce_n_o = !pulse_i;
      assign we_n_o = !(setup_i || pulse_i);
    end
  endgenerate

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
  import sram_bus_pkg::*;
#(
  parameter int CLK_PS    = 10000,
  parameter int T_CYC_PS  = 35000,
  parameter int T_ACC_PS  = 35000,
  parameter int T_WP_PS   = 15000,
  parameter int T_DH_PS   = 5000,
  parameter int T_WEH_PS  = 2000,
  parameter bit WE_CTRL   = 1'b1,
  parameter int AW        = 19,
  parameter int DW        = 8,
  parameter int CNT_W     = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic          wr_inhibit_i,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_data_o,
  output logic          wr_err_o,
  output logic          mem_ce_no,
  output logic          mem_we_no,
  output logic          mem_oe_no,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe_o,
  input  logic [DW-1:0] mem_dq_i
);

  localparam int CYC_N = to_cycles(T_CYC_PS, CLK_PS);
  localparam int ACC_N = to_cycles(T_ACC_PS, CLK_PS);
  localparam int WP_N  = to_cycles(T_WP_PS, CLK_PS);
  localparam int DH_N  = to_cycles(T_DH_PS, CLK_PS);
  localparam int REC_N = to_cycles(T_WEH_PS, CLK_PS);

  sbc_state_e state_q, state_d;

  logic             phase_ld, phase_zero;
  logic [CNT_W-1:0] phase_val;
  logic             ce_gap_zero, we_gap_zero;
  logic             accept, latch, capture, err_d;
  logic             ce_n_q, we_n_q, oe_n_q, dq_oe_q;
  logic             ce_n_d, we_n_d, oe_n_d, dq_oe_d, ce_wr_n;
  logic             ce_fall, we_rise;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q, rdata_q;
  logic             rd_valid_q, err_q;

  assign req_ready_o = (state_q == S_IDLE) && ce_gap_zero && we_gap_zero;
  assign accept      = req_valid_i && req_ready_o;

  always_comb begin
    state_d   = state_q;
    phase_ld  = 1'b0;
    phase_val = '0;
    latch     = 1'b0;
    capture   = 1'b0;
    err_d     = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (accept) begin
          if (req_write_i && wr_inhibit_i) begin
            err_d = 1'b1;
          end else if (req_write_i) begin
            latch    = 1'b1;
            state_d  = S_WSU;
            phase_ld = 1'b1;
          end else begin
            latch     = 1'b1;
            state_d   = S_RD;
            phase_ld  = 1'b1;
            phase_val = CNT_W'(ACC_N - 1);
          end
        end
      end
      S_RD: begin
        if (phase_zero) begin
          capture = 1'b1;
          state_d = S_IDLE;
        end
      end
      S_WSU: begin
        if (phase_zero) begin
          state_d   = S_WP;
          phase_ld  = 1'b1;
          phase_val = CNT_W'(WP_N - 1);
        end
      end
      S_WP: begin
        if (phase_zero) begin
          state_d   = S_WH;
          phase_ld  = 1'b1;
          phase_val = CNT_W'(DH_N - 1);
        end
      end
      S_WH: begin
        if (phase_zero) state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  sbc_wr_strobe #(
    .WE_CTRL (WE_CTRL)
  ) i_wr_strobe (
    .setup_i (state_d == S_WSU),
    .pulse_i (state_d == S_WP),
    .ce_n_o  (ce_wr_n),
    .we_n_o  (we_n_d)
  );

  always_comb begin
    ce_n_d  = ce_wr_n && (state_d != S_RD);
    oe_n_d  = (state_d != S_RD);
    dq_oe_d = (state_d == S_WSU) || (state_d == S_WP) || (state_d == S_WH);
    ce_fall = ce_n_q && !ce_n_d;
    we_rise = !we_n_q && we_n_d;
  end

  sbc_down_cnt #(.CNT_W(CNT_W)) i_phase_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (phase_ld),
    .val_i  (phase_val),
    .zero_o (phase_zero)
  );

  // spacing between chip-enable falls
  sbc_down_cnt #(.CNT_W(CNT_W)) i_ce_gap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ce_fall),
    .val_i  (CNT_W'(CYC_N - 1)),
    .zero_o (ce_gap_zero)
  );

  // write-enable high time
  sbc_down_cnt #(.CNT_W(CNT_W)) i_we_gap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (we_rise),
    .val_i  (CNT_W'(REC_N - 1)),
    .zero_o (we_gap_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      ce_n_q     <= 1'b1;
      we_n_q     <= 1'b1;
      oe_n_q     <= 1'b1;
      dq_oe_q    <= 1'b0;
      addr_q     <= '0;
      wdata_q    <= '0;
      rdata_q    <= '0;
      rd_valid_q <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      state_q    <= state_d;
      ce_n_q     <= ce_n_d;
      we_n_q     <= we_n_d;
      oe_n_q     <= oe_n_d;
      dq_oe_q    <= dq_oe_d;
      rd_valid_q <= capture;
      err_q      <= err_d;
      if (latch) begin
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
      end
      if (capture) rdata_q <= mem_dq_i;
    end
  end

  assign mem_ce_no   = ce_n_q;
  assign mem_we_no   = we_n_q;
  assign mem_oe_no   = oe_n_q;
  assign mem_addr_o  = addr_q;
  assign mem_dq_o    = wdata_q;
  assign mem_dq_oe_o = dq_oe_q;
  assign rd_valid_o  = rd_valid_q;
  assign rd_data_o   = rdata_q;
  assign wr_err_o    = err_q;

endmodule

// File: rtl/sbc_checker.sv
module sbc_checker #(
  parameter bit WE_CTRL = 1'b1,
  parameter int AW      = 19
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_ready_o,
  input logic          rd_valid_o,
  input logic          wr_err_o,
  input logic          mem_ce_no,
  input logic          mem_we_no,
  input logic          mem_oe_no,
  input logic          mem_dq_oe_o,
  input logic [AW-1:0] mem_addr_o
);

  p_rd_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);

  p_no_contention_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_no);

  p_err_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_err_o |-> (mem_ce_no && mem_we_no && req_ready_o));

  p_busy_not_ready_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_ce_no |-> !req_ready_o);

  p_addr_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce_no && !$past(mem_ce_no)) |-> $stable(mem_addr_o));

  generate
    if (WE_CTRL) begin : g_we
      p_ce_leads_we_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(mem_we_no) |-> !$past(mem_ce_no));
      p_joint_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(mem_we_no) |-> mem_ce_no);
    end else begin : g_ce
      p_we_leads_ce_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(mem_ce_no) && !mem_we_no) |-> !$past(mem_we_no));
      p_joint_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(mem_we_no) |-> mem_ce_no);
    end
  endgenerate

endmodule

bind sram_bus_ctrl sbc_checker #(
  .WE_CTRL (WE_CTRL),
  .AW      (AW)
) i_sbc_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .rd_valid_o  (rd_valid_o),
  .wr_err_o    (wr_err_o),
  .mem_ce_no   (mem_ce_no),
  .mem_we_no   (mem_we_no),
  .mem_oe_no   (mem_oe_no),
  .mem_dq_oe_o (mem_dq_oe_o),
  .mem_addr_o  (mem_addr_o)
);

// File: tb/sbc_env.sv
module sbc_env #(
  parameter bit          WE_CTRL = 1'b1,
  parameter int unsigned SEED    = 1
) (
  input  logic clk,
  input  logic rst_n,
  output int   n_run,
  output int   n_fail,
  output logic done
);

  // default timing of the controller, in clocks, rounded up
  localparam int CYC_N = 4;
  localparam int ACC_N = 4;
  localparam int WP_N  = 2;
  localparam int REC_N = 1;

  logic        req_valid, req_ready, req_write, wr_inhibit;
  logic [18:0] req_addr;
  logic [7:0]  req_wdata;
  logic        rd_valid, wr_err;
  logic [7:0]  rd_data;
  logic        ce_n, we_n, oe_n, dq_oe;
  logic [18:0] mem_addr;
  logic [7:0]  dq_out, dq_in;

  sram_bus_ctrl #(.WE_CTRL(WE_CTRL)) i_sram_bus_ctrl (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .req_valid_i  (req_valid),
    .req_ready_o  (req_ready),
    .req_write_i  (req_write),
    .req_addr_i   (req_addr),
    .req_wdata_i  (req_wdata),
    .wr_inhibit_i (wr_inhibit),
    .rd_valid_o   (rd_valid),
    .rd_data_o    (rd_data),
    .wr_err_o     (wr_err),
    .mem_ce_no    (ce_n),
    .mem_we_no    (we_n),
    .mem_oe_no    (oe_n),
    .mem_addr_o   (mem_addr),
    .mem_dq_o     (dq_out),
    .mem_dq_oe_o  (dq_oe),
    .mem_dq_i     (dq_in)
  );

  logic [7:0] mem_m [int unsigned];
  logic [7:0] exp_m [int unsigned];

  function automatic logic [7:0] init_byte(logic [18:0] a);
    return a[7:0] ^ a[15:8] ^ {a[18:16], 5'h15};
  endfunction

  function automatic logic [7:0] mem_rd(logic [18:0] a);
    if (mem_m.exists(int'(a))) return mem_m[int'(a)];
    return init_byte(a);
  endfunction

  function automatic logic [7:0] exp_rd(logic [18:0] a);
    if (exp_m.exists(int'(a))) return exp_m[int'(a)];
    return init_byte(a);
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s (WE_CTRL=%0d): actual %0h expected %0h", tag, what, WE_CTRL, act, expv);
    end
  endtask

  // memory model and pin monitor
  int         cyc, last_ce_fall, last_we_rise, ce_low, ovl;
  bit         have_fall, have_rise, prev_ce, prev_we;
  logic [18:0] prev_addr;
  logic [7:0] lat;

  initial begin
    dq_in = 8'hEE; cyc = 0; ce_low = 0; ovl = 0;
    have_fall = 0; have_rise = 0; prev_ce = 1; prev_we = 1; prev_addr = '0;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (!oe_n && dq_oe) check(0, "R4", "output enable low while driving", 0, 1);
      if (!ce_n && prev_ce) begin
        if (have_fall) check(cyc - last_ce_fall >= CYC_N, "R5", "chip enable fall spacing",
                             cyc - last_ce_fall, CYC_N);
        have_fall = 1; last_ce_fall = cyc;
        if (!WE_CTRL && !we_n) check(!prev_we, "R3", "write enable low before chip enable", 1, 0);
      end
      if (!we_n && prev_we) begin
        if (have_rise) check(cyc - last_we_rise >= REC_N, "R6", "write enable high time",
                             cyc - last_we_rise, REC_N);
        if (WE_CTRL) check(!prev_ce, "R2", "chip enable low before write enable", 1, 0);
      end
      if (we_n && !prev_we) begin
        have_rise = 1; last_we_rise = cyc;
      end
      if (!ce_n && !prev_ce && mem_addr != prev_addr)
        check(0, "R9", "address moved under chip enable", int'(mem_addr), int'(prev_addr));
      ce_low = ce_n ? 0 : ce_low + 1;
      if (!ce_n && !we_n) begin
        ovl++;
        lat = dq_out;
        if (!dq_oe) check(0, "R4", "bus not driven in overlap", 0, 1);
      end else if (ovl > 0) begin
        check(ovl >= WP_N, WE_CTRL ? "R2" : "R3", "write strobe overlap", ovl, WP_N);
        check(dq_oe, "R4", "data hold after strobe", 0, 1);
        if (ovl >= WP_N) mem_m[int'(mem_addr)] = lat;
        ovl = 0;
      end
      dq_in = (!ce_n && !oe_n && we_n && ce_low >= ACC_N) ? mem_rd(mem_addr) : 8'hEE;
      prev_ce = ce_n; prev_we = we_n; prev_addr = mem_addr;
    end
  end

  // entered and left at a falling edge
  task automatic do_op(bit wr, logic [18:0] a, logic [7:0] d, bit inh);
    int guard;
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; wr_inhibit = inh;
    @(negedge clk);
    req_valid = 0;
    if (wr && inh) begin
      check(wr_err == 1'b1, "R7", "refused write error pulse", wr_err, 1);
      check(req_ready && ce_n && we_n, "R7", "refused write leaves pins idle", 0, 1);
      wr_inhibit = 0;
    end else begin
      check(req_ready == 1'b0, "R8", "ready drops after accept", req_ready, 0);
      check(wr_err == 1'b0, "R7", "no error on normal request", wr_err, 0);
      if (wr) exp_m[int'(a)] = d;
    end
    if (!wr) begin
      guard = 0;
      while (!rd_valid && guard < 40) begin
        @(negedge clk);
        guard++;
      end
      check(rd_valid == 1'b1, "R1", "read completes", rd_valid, 1);
      check(rd_data == exp_rd(a), "R1", "read byte", rd_data, exp_rd(a));
      check(req_ready == 1'b1, "R8", "ready in read valid cycle", req_ready, 1);
    end
  endtask

  initial begin
    n_run = 0; n_fail = 0; done = 0;
    req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0; wr_inhibit = 0;
    void'($urandom(SEED));
    wait (rst_n);
    @(negedge clk);
    check(req_ready && ce_n && we_n && oe_n, "R10", "reset ready and strobes", 0, 1);
    check(!dq_oe && !rd_valid && !wr_err, "R10", "reset driver and pulses", 1, 0);
    // directed corners
    do_op(1, 19'h00010, 8'h5A, 0);
    do_op(0, 19'h00010, 8'h00, 0);
    do_op(0, 19'h7FFFF, 8'h00, 0);
    do_op(1, 19'h00010, 8'hFF, 1);
    do_op(0, 19'h00010, 8'h00, 0);
    do_op(1, 19'h7FFFF, 8'hC3, 0);
    do_op(1, 19'h7FFFF, 8'h3C, 0);
    do_op(0, 19'h7FFFF, 8'h00, 0);
    do_op(0, 19'h00000, 8'h00, 0);
    do_op(1, 19'h00000, 8'h81, 1);
    do_op(0, 19'h00000, 8'h00, 0);
    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [31:0] r;
      logic [18:0] a;
      bit wr, inh;
      r   = $urandom;
      wr  = r[0];
      inh = wr && (r[3:1] == 3'd0);
      a   = r[5] ? 19'($urandom) : {15'd0, r[9:6]};
      do_op(wr, a, 8'($urandom), inh);
    end
    repeat (8) @(negedge clk);
    done = 1;
  end

endmodule

// File: tb/test_sram_bus_ctrl.sv
module test_sram_bus_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   run_we, fail_we, run_ce, fail_ce;
  logic done_we, done_ce;
  int   extra_fail;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sbc_env #(.WE_CTRL(1'b1), .SEED(17)) i_env_we (
    .clk (clk), .rst_n (rst_n), .n_run (run_we), .n_fail (fail_we), .done (done_we)
  );

  sbc_env #(.WE_CTRL(1'b0), .SEED(91)) i_env_ce (
    .clk (clk), .rst_n (rst_n), .n_run (run_ce), .n_fail (fail_ce), .done (done_ce)
  );

  initial begin
    extra_fail = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    fork
      wait (done_we === 1'b1 && done_ce === 1'b1);
      repeat (WATCHDOG) @(posedge clk);
    join_any
    disable fork;
    if (!(done_we === 1'b1 && done_ce === 1'b1)) begin
      extra_fail = 1;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("[TB] %0d tests run, %0d failed", run_we + run_ce + extra_fail,
             fail_we + fail_ce + extra_fail);
    $finish;
  end

endmodule